// File: doc/BRIEF.md
# Out-of-Order Completion Scoreboard Controller

This block is the central hazard tracker for a small floating-point pipeline. Decoded instructions arrive in program order. Each carries a target functional unit, an operation code, one destination register and two source registers. The controller tracks every non-pipelined unit and every register, and it decides four things each cycle. It decides when an instruction may enter a unit, and when that unit may fetch its operands from the register file. It records when the unit has finished, and it decides when the finished unit may write its result back.

The controller holds two tables. The unit table stores, for each unit, its phase, operation, destination, sources, the producing unit for each source and one ready flag for each source. The register table names the unit that will write each register, if any. From these tables the block drives three strobe vectors: start, operand read and result write. It also drives the register being written on the current cycle and the operation held by each unit. Each unit reports completion with a one-cycle done pulse.

The block applies these rules:
- An instruction waits at issue if its target unit is busy or another active instruction already targets the same destination.
- A unit waits to read its operands until both sources are ready.
- A finished unit waits to write back while some other unit still needs the old value of its destination register.

Top module: `sb_ctrl`

## Requirements
- R1: After reset, every unit is idle and no register has a pending writer. `in_ready` is high, `fu_start`, `fu_read` and `fu_write` are all zero, and every `unit_op` slice is zero.
- R2: `in_ready` is high exactly when the unit numbered `in_fu` is idle and no active instruction has `in_dst` as its destination. Otherwise the head instruction stalls.
- R3: Issue happens in order. `fu_start` is nonzero only in a cycle where `in_valid` and `in_ready` are both high. It then has exactly bit `in_fu` set, so a stalled head blocks every later instruction.
- R4: Status is registered. A unit or destination released by a writeback in cycle t can be issued to no earlier than cycle t+1, and a unit that is started in cycle t is busy in cycle t+1.
- R5: Bit u of `fu_read` pulses once per instruction, in the first cycle after issue in which both of its sources have no pending writer left. A source whose writer writes back in cycle t counts as ready from cycle t+1. A source whose writer is writing back in the issue cycle itself counts as ready at once. Several units may read in the same cycle.
- R6: A `fu_done` bit counts only for a unit that has read its operands and has not yet reported done. The unit can then request writeback from the next cycle. A done pulse to any other unit has no effect.
- R7: A finished unit writes (bit u of `fu_write` high, `wr_reg` equal to its destination) only when no other busy unit still has that register as a source whose ready flag is set and that it has not yet read. Otherwise the write waits.
- R8: At most one bit of `fu_write` is high in a cycle. Among units that may write, the lowest index wins.
- R9: Slice u of `unit_op` (bits u*OP_W and up) shows the operation of the instruction held by unit u. It is zero from the cycle after that unit's writeback until its next start.
- R10: Once a unit has read its operands, those sources no longer block any writeback. Issue-time readiness uses the register table, so a source with no pending writer is ready at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Head instruction present |
| in_fu | input | FU_W | Target functional unit index |
| in_op | input | OP_W | Operation code |
| in_dst | input | REG_W | Destination register |
| in_src1 | input | REG_W | First source register |
| in_src2 | input | REG_W | Second source register |
| in_ready | output | 1 | Head instruction may issue this cycle |
| fu_start | output | NFU | Per-unit issue strobe |
| fu_read | output | NFU | Per-unit operand-read strobe, execution begins |
| fu_done | input | NFU | Per-unit completion pulse |
| fu_write | output | NFU | Per-unit result write strobe |
| wr_reg | output | REG_W | Register written by the granted unit |
| unit_op | output | NFU*OP_W | Operation held by each unit |

## Verification
The hardest situation to reach is a writeback held back by a read that has not yet happened. This needs a fast unit to finish while a slower, earlier-issued instruction still holds the fast unit's destination as a ready but unread source, and that instruction must itself be waiting on another long operation. The bench sets this up with a directed sequence: a long divide-like operation feeds a consumer that also reads the register which a one-cycle unit then overwrites. A long random phase follows over only eight registers, with unit latencies of 1, 2, 3 and 6 cycles. That phase produces WAW stalls, same-cycle writeback contention and stray done pulses to units that are not executing. A behavioural model predicts every strobe on every cycle.

// File: rtl/sb_pkg.sv
package sb_pkg;
    typedef enum logic [1:0] {
        PH_IDLE     = 2'd0,
        PH_WAIT_OPS = 2'd1,
        PH_EXEC     = 2'd2,
        PH_WAIT_WR  = 2'd3
    } sb_phase_e;
endpackage

// File: rtl/sb_issue_gate.sv
module sb_issue_gate #(
    parameter int NFU   = 4,
    parameter int NREG  = 16,
    parameter int FU_W  = 2,
    parameter int REG_W = 4
) (
    input  logic             in_valid,
    input  logic [FU_W-1:0]  in_fu,
    input  logic [REG_W-1:0] in_dst,
    input  logic [NFU-1:0]   busy,
    input  logic [NREG-1:0]  pend,
    output logic             ready,
    output logic [NFU-1:0]   start
);
    logic unit_free;

    // structural and WAW check against registered tables
    always_comb begin
        unit_free = 1'b0;
        for (int u = 0; u < NFU; u++) begin
            if (in_fu == FU_W'(u)) unit_free = !busy[u];
        end
        ready = unit_free && !pend[in_dst];
    end

    for (genvar u = 0; u < NFU; u++) begin : g_start
        assign start[u] = in_valid && ready && (in_fu == FU_W'(u));
    end
endmodule

// File: rtl/sb_wb_arb.sv
module sb_wb_arb #(
    parameter int NFU   = 4,
    parameter int FU_W  = 2,
    parameter int REG_W = 4
) (
    input  logic [NFU-1:0]            cand,
    input  logic [NFU-1:0]            busy,
    input  logic [NFU-1:0][REG_W-1:0] fi,
    input  logic [NFU-1:0][REG_W-1:0] fj,
    input  logic [NFU-1:0][REG_W-1:0] fk,
    input  logic [NFU-1:0]            rj,
    input  logic [NFU-1:0]            rk,
    output logic [NFU-1:0]            grant,
    output logic [FU_W-1:0]           gidx,
    output logic                      any
);
    logic [NFU-1:0] blocked;
    logic [NFU-1:0] elig;

    // WAR: another unit still owes a read of this destination
    always_comb begin
        blocked = '0;
        for (int u = 0; u < NFU; u++) begin
            for (int v = 0; v < NFU; v++) begin
                if (v != u && busy[v] &&
                    ((fj[v] == fi[u] && rj[v]) || (fk[v] == fi[u] && rk[v])))
                    blocked[u] = 1'b1;
            end
        end
        elig = cand & ~blocked;
    end

    // fixed priority, lowest index wins
    always_comb begin
        grant = '0;
        gidx  = '0;
        any   = 1'b0;
        for (int u = NFU - 1; u >= 0; u--) begin
            if (elig[u]) begin
                grant    = '0;
                grant[u] = 1'b1;
                gidx     = FU_W'(u);
                any      = 1'b1;
            end
        end
    end
endmodule

// File: rtl/sb_ctrl.sv
module sb_ctrl #(
    parameter int NFU  = 4,
    parameter int NREG = 16,
    parameter int OP_W = 4,
    localparam int FU_W  = (NFU > 1) ? $clog2(NFU) : 1,
    localparam int REG_W = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [FU_W-1:0]     in_fu,
    input  logic [OP_W-1:0]     in_op,
    input  logic [REG_W-1:0]    in_dst,
    input  logic [REG_W-1:0]    in_src1,
    input  logic [REG_W-1:0]    in_src2,
    output logic                in_ready,
    output logic [NFU-1:0]      fu_start,
    output logic [NFU-1:0]      fu_read,
    input  logic [NFU-1:0]      fu_done,
    output logic [NFU-1:0]      fu_write,
    output logic [REG_W-1:0]    wr_reg,
    output logic [NFU*OP_W-1:0] unit_op
);
    import sb_pkg::*;

    typedef struct packed {
        sb_phase_e        ph;
        logic [OP_W-1:0]  op;
        logic [REG_W-1:0] fi;
        logic [REG_W-1:0] fj;
        logic [REG_W-1:0] fk;
        logic [FU_W-1:0]  qj;
        logic [FU_W-1:0]  qk;
        logic             qjv;
        logic             qkv;
        logic             rj;
        logic             rk;
    } fu_ent_t;

    typedef struct packed {
        fu_ent_t [NFU-1:0]             fu;
        logic [NREG-1:0]               rv;
        logic [NREG-1:0][FU_W-1:0]     ru;
    } state_t;

    state_t state_q, state_d;

    logic [NFU-1:0]            busy, cand, rj_v, rk_v, grant;
    logic [NFU-1:0][REG_W-1:0] fi_v, fj_v, fk_v;
    logic [FU_W-1:0]           gidx;
    logic                      wr_any;
    logic [NFU-1:0]            rd_d;

    for (genvar u = 0; u < NFU; u++) begin : g_view
        assign busy[u] = state_q.fu[u].ph != PH_IDLE;
        assign cand[u] = state_q.fu[u].ph == PH_WAIT_WR;
        assign fi_v[u] = state_q.fu[u].fi;
        assign fj_v[u] = state_q.fu[u].fj;
        assign fk_v[u] = state_q.fu[u].fk;
        assign rj_v[u] = state_q.fu[u].rj;
        assign rk_v[u] = state_q.fu[u].rk;
        assign unit_op[u*OP_W +: OP_W] = state_q.fu[u].op;
    end

    sb_issue_gate #(.NFU(NFU), .NREG(NREG), .FU_W(FU_W), .REG_W(REG_W)) i_gate (
        .in_valid (in_valid),
        .in_fu    (in_fu),
        .in_dst   (in_dst),
        .busy     (busy),
        .pend     (state_q.rv),
        .ready    (in_ready),
        .start    (fu_start)
    );

    sb_wb_arb #(.NFU(NFU), .FU_W(FU_W), .REG_W(REG_W)) i_arb (
        .cand  (cand),
        .busy  (busy),
        .fi    (fi_v),
        .fj    (fj_v),
        .fk    (fk_v),
        .rj    (rj_v),
        .rk    (rk_v),
        .grant (grant),
        .gidx  (gidx),
        .any   (wr_any)
    );

    assign fu_write = grant;
    assign fu_read  = rd_d;
    assign wr_reg   = wr_any ? state_q.fu[gidx].fi : '0;

    always_comb begin
        fu_ent_t ent;
        state_d = state_q;
        rd_d    = '0;
        ent     = '0;

        // read operands / execution handshake
        for (int u = 0; u < NFU; u++) begin
            if (state_q.fu[u].ph == PH_WAIT_OPS && state_q.fu[u].rj && state_q.fu[u].rk) begin
                rd_d[u]           = 1'b1;
                state_d.fu[u].ph  = PH_EXEC;
                state_d.fu[u].rj  = 1'b0;
                state_d.fu[u].rk  = 1'b0;
            end else if (state_q.fu[u].ph == PH_EXEC && fu_done[u]) begin
                state_d.fu[u].ph  = PH_WAIT_WR;
            end
        end

        // write result: free writer, wake its consumers
        if (wr_any) begin
            state_d.rv[state_q.fu[gidx].fi] = 1'b0;
            state_d.fu[gidx] = '0;
            for (int v = 0; v < NFU; v++) begin
                if (state_q.fu[v].qjv && state_q.fu[v].qj == gidx) begin
                    state_d.fu[v].qjv = 1'b0;
                    state_d.fu[v].rj  = 1'b1;
                end
                if (state_q.fu[v].qkv && state_q.fu[v].qk == gidx) begin
                    state_d.fu[v].qkv = 1'b0;
                    state_d.fu[v].rk  = 1'b1;
                end
            end
        end

        // issue
        if (|fu_start) begin
            ent.ph  = PH_WAIT_OPS;
            ent.op  = in_op;
            ent.fi  = in_dst;
            ent.fj  = in_src1;
            ent.fk  = in_src2;
            ent.qj  = state_q.ru[in_src1];
            ent.qk  = state_q.ru[in_src2];
            ent.qjv = state_q.rv[in_src1] && !(wr_any && state_q.ru[in_src1] == gidx);
            ent.qkv = state_q.rv[in_src2] && !(wr_any && state_q.ru[in_src2] == gidx);
            ent.rj  = !ent.qjv;
            ent.rk  = !ent.qkv;
            state_d.fu[in_fu]  = ent;
            state_d.rv[in_dst] = 1'b1;
            state_d.ru[in_dst] = in_fu;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    a_r8_single_write: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fu_write));

    for (genvar u = 0; u < NFU; u++) begin : g_chk
        a_r4_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
            fu_start[u] |=> !fu_start[u]);
        a_r5_no_read_at_issue: assert property (@(posedge clk) disable iff (!rst_n)
            fu_start[u] |-> !fu_read[u]);
        a_r6_done_before_write: assert property (@(posedge clk) disable iff (!rst_n)
            fu_read[u] |=> !fu_write[u]);
        a_r9_free_after_write: assert property (@(posedge clk) disable iff (!rst_n)
            fu_write[u] |=> (unit_op[u*OP_W +: OP_W] == '0));
    end
endmodule

// File: tb/test_sb_ctrl.sv
`timescale 1ns/1ps
module test_sb_ctrl;
    localparam int NFU = 4;
    localparam int NREG = 16;
    localparam int OP_W = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [1:0] in_fu = '0;
    logic [OP_W-1:0] in_op = '0;
    logic [3:0] in_dst = '0, in_src1 = '0, in_src2 = '0;
    logic in_ready;
    logic [NFU-1:0] fu_start, fu_read, fu_write;
    logic [NFU-1:0] fu_done = '0;
    logic [3:0] wr_reg;
    logic [NFU*OP_W-1:0] unit_op;

    always #2.5 clk = ~clk;

    sb_ctrl #(.NFU(NFU), .NREG(NREG), .OP_W(OP_W)) i_sb_ctrl (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_fu(in_fu), .in_op(in_op),
        .in_dst(in_dst), .in_src1(in_src1), .in_src2(in_src2), .in_ready(in_ready),
        .fu_start(fu_start), .fu_read(fu_read), .fu_done(fu_done), .fu_write(fu_write),
        .wr_reg(wr_reg), .unit_op(unit_op)
    );

    typedef struct { int fu; int op; int dst; int s1; int s2; } ins_t;
    ins_t prog[$];

    int total = 0, bad = 0;
    bit finished = 0, stray = 0;

    // reference model: phase 0 idle, 1 waiting operands, 2 executing, 3 waiting write
    int m_ph[NFU], m_op[NFU], m_fi[NFU], m_fj[NFU], m_fk[NFU];
    int m_qj[NFU], m_qk[NFU], m_rj[NFU], m_rk[NFU], m_cnt[NFU];
    int m_res[NREG];

    function automatic int lat(int u);
        case (u)
            0: return 1;
            1: return 3;
            2: return 6;
            default: return 2;
        endcase
    endfunction

    task automatic chk(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic push(int fu, int dst, int s1, int s2);
        ins_t i;
        i.fu = fu; i.op = $urandom_range(1, 15); i.dst = dst; i.s1 = s1; i.s2 = s2;
        prog.push_back(i);
    endtask

    function automatic bit war_block(int u);
        for (int v = 0; v < NFU; v++)
            if (v != u && m_ph[v] != 0 &&
                ((m_fj[v] == m_fi[u] && m_rj[v] != 0) || (m_fk[v] == m_fi[u] && m_rk[v] != 0)))
                return 1;
        return 0;
    endfunction

    function automatic bit all_idle();
        for (int u = 0; u < NFU; u++) if (m_ph[u] != 0) return 0;
        return 1;
    endfunction

    task automatic step();
        logic [NFU-1:0] e_start, e_read, e_write, dv;
        int e_ready, w, u;
        @(negedge clk);
        if (prog.size() > 0) begin
            in_valid = 1'b1;
            in_fu = 2'(prog[0].fu); in_op = 4'(prog[0].op);
            in_dst = 4'(prog[0].dst); in_src1 = 4'(prog[0].s1); in_src2 = 4'(prog[0].s2);
        end else begin
            in_valid = 1'b0;
            in_fu = 2'($urandom_range(0, 3)); in_dst = 4'($urandom_range(0, 15));
        end
        for (int k = 0; k < NFU; k++) begin
            dv[k] = (m_ph[k] == 2 && m_cnt[k] == 0);
            if (stray && m_ph[k] != 2 && $urandom_range(0, 3) == 0) dv[k] = 1'b1; // R6 stimulus
        end
        fu_done = dv;
        #1;
        e_ready = (m_ph[int'(in_fu)] == 0 && m_res[int'(in_dst)] < 0) ? 1 : 0;
        e_start = '0;
        if (in_valid && e_ready != 0) e_start[in_fu] = 1'b1;
        for (int k = 0; k < NFU; k++)
            e_read[k] = (m_ph[k] == 1 && m_rj[k] != 0 && m_rk[k] != 0);
        w = -1;
        for (int k = 0; k < NFU; k++)
            if (w < 0 && m_ph[k] == 3 && !war_block(k)) w = k;
        e_write = '0;
        if (w >= 0) e_write[w] = 1'b1;

        chk("R2/R4 in_ready", int'(in_ready), e_ready);
        chk("R3 fu_start", int'(fu_start), int'(e_start));
        chk("R5/R10 fu_read", int'(fu_read), int'(e_read));
        chk("R6/R7/R8/R10 fu_write", int'(fu_write), int'(e_write));
        if (w >= 0) chk("R7 wr_reg", int'(wr_reg), m_fi[w]);
        for (int k = 0; k < NFU; k++)
            chk("R9 unit_op", int'(unit_op[k*OP_W +: OP_W]), m_op[k]);

        // advance the model
        for (int k = 0; k < NFU; k++) begin
            if (e_read[k]) begin
                m_ph[k] = 2; m_rj[k] = 0; m_rk[k] = 0; m_cnt[k] = lat(k) - 1;
            end else if (m_ph[k] == 2) begin
                if (dv[k]) m_ph[k] = 3;
                else m_cnt[k]--;
            end
        end
        if (w >= 0) begin
            m_res[m_fi[w]] = -1;
            m_ph[w] = 0; m_op[w] = 0; m_qj[w] = -1; m_qk[w] = -1; m_rj[w] = 0; m_rk[w] = 0;
            for (int v = 0; v < NFU; v++) begin
                if (m_qj[v] == w) begin m_qj[v] = -1; m_rj[v] = 1; end
                if (m_qk[v] == w) begin m_qk[v] = -1; m_rk[v] = 1; end
            end
        end
        if (e_start != 0) begin
            u = int'(in_fu);
            m_ph[u] = 1; m_op[u] = int'(in_op);
            m_fi[u] = int'(in_dst); m_fj[u] = int'(in_src1); m_fk[u] = int'(in_src2);
            m_qj[u] = m_res[m_fj[u]]; m_qk[u] = m_res[m_fk[u]];
            m_rj[u] = (m_qj[u] < 0) ? 1 : 0; m_rk[u] = (m_qk[u] < 0) ? 1 : 0;
            m_res[m_fi[u]] = u;
            void'(prog.pop_front());
        end
    endtask

    task automatic drain();
        int n = 0;
        while ((prog.size() > 0 || !all_idle()) && n < 3000) begin
            step();
            n++;
        end
        repeat (2) step();
    endtask

    initial begin
        for (int u = 0; u < NFU; u++) begin
            m_ph[u] = 0; m_op[u] = 0; m_fi[u] = 0; m_fj[u] = 0; m_fk[u] = 0;
            m_qj[u] = -1; m_qk[u] = -1; m_rj[u] = 0; m_rk[u] = 0; m_cnt[u] = 0;
        end
        for (int r = 0; r < NREG; r++) m_res[r] = -1;

        repeat (3) @(negedge clk);
        #1;
        chk("R1 reset in_ready", int'(in_ready), 1);
        chk("R1 reset fu_start", int'(fu_start), 0);
        chk("R1 reset fu_read", int'(fu_read), 0);
        chk("R1 reset fu_write", int'(fu_write), 0);
        chk("R1 reset unit_op", int'(unit_op), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // independent work on every unit
        push(0, 1, 2, 3); push(1, 4, 5, 6); push(2, 7, 8, 9); push(3, 10, 11, 12);
        drain();
        // RAW chain, both sources from one producer
        push(2, 2, 4, 5); push(1, 6, 2, 2); push(3, 7, 6, 2);
        drain();
        // structural stall on one unit
        push(1, 1, 3, 3); push(1, 5, 3, 3); push(0, 9, 1, 5);
        drain();
        // WAW stall
        push(2, 0, 1, 1); push(0, 0, 2, 2);
        drain();
        // WAR: fast writer of r8 must wait for the consumer's read
        push(2, 0, 2, 4); push(1, 10, 0, 8); push(0, 8, 8, 14);
        drain();
        // random traffic over eight registers with stray done pulses
        stray = 1;
        for (int i = 0; i < 400; i++)
            push($urandom_range(0, 3), $urandom_range(0, 7), $urandom_range(0, 7), $urandom_range(0, 7));
        drain();

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog expired act=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule